// File: doc/BRIEF.md
# Per-Core Timer Compare Interrupt Unit

This unit belongs to one processor core. It holds a 64-bit alarm value and compares it, every cycle, with a shared free-running 64-bit timebase that is generated elsewhere. As soon as the timebase reaches or passes the alarm value, the unit latches a pending flag and drives a level interrupt to its own core. The flag stays latched after the timebase falls below the alarm value again, for example after the counter wraps or is reloaded. Software clears the flag by writing to the alarm value, which is normally how it also schedules the next alarm.

Software reaches the alarm value as two 32-bit words on a simple register bus. Reads return data one cycle after the request. A build parameter removes the comparator entirely. In that build the register reads as zero, ignores writes, and never raises the interrupt. This is intended for cores that rely on another core for timer service.

Top module: `hart_alarm`

## Requirements
- R1: After synchronous reset, `irq_o` and `rdata_o` are 0, and both alarm words read back as 0xFFFFFFFF, so the interrupt stays quiet until software programs a value.
- R2: When no write occurs in a cycle and the timebase is greater than or equal to the 64-bit alarm value at a rising edge, `irq_o` is 1 after that edge. Equality is enough to post. A timebase one below the alarm value does not post.
- R3: Once `irq_o` is 1, it stays 1 regardless of the timebase until a write reaches an alarm word.
- R4: A write to either alarm word clears `irq_o` at the edge that performs the write, even if the timebase meets the alarm value. If the timebase still meets the updated value, `irq_o` returns to 1 one edge later.
- R5: A read returns the addressed word on `rdata_o` after the next rising edge. A read in the same cycle as a write to the same word returns the value held before the write. `rdata_o` holds its value in cycles without a read.
- R6: Byte offset 0x0 maps to alarm bits 31:0 and offset 0x4 maps to bits 63:32. The comparison covers all 64 bits, so a timebase with a larger upper word and a smaller lower word still posts.
- R7: An access whose offset is not 0x0 or 0x4 (any offset with bit 1 or bit 0 set) reads as 0, changes no alarm word, and does not clear a pending interrupt.
- R8: The three-step update sequence (lower word set to 0xFFFFFFFF, then the new upper word, then the new lower word) raises no interrupt at any point when the timebase is below both the old and the new alarm values.
- R9: With `HAS_CMP` = 0, both words read as 0, writes have no effect, and `irq_o` is never 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timebase_i | input | 64 | Shared timebase count |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 3 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt to the owning core |

## Verification
Two functions can fall on the same edge. One is the clear that a comparator write causes. The other is the set that the compare causes when the timebase already meets the alarm value. The bench sets up this collision by writing an alarm word while the timebase sits above both the old and the new value. It then requires `irq_o` to be low right after the write edge and high one edge later. A second collision is a read and a write to the same word in one cycle. The bench judges it by requiring the pre-write value on `rdata_o` and the new value on the following read.

// File: rtl/hart_alarm_pkg.sv
package hart_alarm_pkg;

  // Per-word comparison result of timebase against alarm.
  typedef struct packed {
    logic gt;
    logic eq;
  } word_flag_t;

  // Byte-lane bits below the word index for a given data width.
  function automatic int unsigned lane_bits(input int unsigned data_w);
    return $clog2(data_w / 8);
  endfunction

endpackage

// File: rtl/alarm_decode.sv
module alarm_decode #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned LSB    = 2,
  parameter int unsigned NWORDS = 2,
  localparam int unsigned IDX_W = ADDR_W - LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic aligned;

  assign aligned = (addr_i[LSB-1:0] == '0);
  assign idx_o   = addr_i[ADDR_W-1:LSB];
  assign hit_o   = aligned && (int'(idx_o) < NWORDS);

endmodule

// File: rtl/alarm_store.sv
module alarm_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWORDS = 2,
  parameter int unsigned IDX_W  = 1,
  localparam int unsigned VAL_W = DATA_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [VAL_W-1:0]  value_o
);

  logic [DATA_W-1:0] word_q [NWORDS];

  // One register per word; reset to all ones keeps the compare unmet.
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[w] <= '1;
      end else if (wr_i && hit_i && (idx_i == IDX_W'(w))) begin
        word_q[w] <= wdata_i;
      end
    end
    assign value_o[w*DATA_W +: DATA_W] = word_q[w];
  end

  // Registered read port: old contents on a same-cycle write.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= hit_i ? word_q[idx_i] : '0;
    end
  end

  p_rdata_hold_r5 : assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));

  p_bad_offset_r7 : assert property (@(posedge clk) disable iff (rst)
    (rd_i && !hit_i) |=> (rdata_o == '0));

endmodule

// File: rtl/alarm_ge.sv
module alarm_ge
  import hart_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWORDS = 2,
  localparam int unsigned VAL_W = DATA_W * NWORDS
) (
  input  logic [VAL_W-1:0] count_i,
  input  logic [VAL_W-1:0] alarm_i,
  output logic             ge_o
);

  word_flag_t flag [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_flag
    assign flag[w].gt = count_i[w*DATA_W +: DATA_W] > alarm_i[w*DATA_W +: DATA_W];
    assign flag[w].eq = count_i[w*DATA_W +: DATA_W] == alarm_i[w*DATA_W +: DATA_W];
  end

  // The most significant unequal word decides; all equal counts as met.
  always_comb begin
    logic decided;
    decided = 1'b0;
    ge_o    = 1'b1;
    for (int w = NWORDS - 1; w >= 0; w--) begin
      if (!decided && !flag[w].eq) begin
        ge_o    = flag[w].gt;
        decided = 1'b1;
      end
    end
  end

endmodule

// File: rtl/alarm_pend.sv
module alarm_pend (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic met_i,
  output logic pend_o
);

  // Clear beats set: a write always wins its own edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end else if (met_i) begin
      pend_o <= 1'b1;
    end
  end

  p_post_r2 : assert property (@(posedge clk) disable iff (rst)
    (met_i && !clr_i) |=> pend_o);

  p_quiet_r2 : assert property (@(posedge clk) disable iff (rst)
    (!met_i && !pend_o) |=> !pend_o);

  p_sticky_r3 : assert property (@(posedge clk) disable iff (rst)
    (pend_o && !clr_i) |=> pend_o);

  p_write_clears_r4 : assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !pend_o);

endmodule

// File: rtl/hart_alarm.sv
module hart_alarm
  import hart_alarm_pkg::*;
#(
  parameter bit          HAS_CMP = 1'b1,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  timebase_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned NWORDS = CNT_W / DATA_W;
  localparam int unsigned LSB    = lane_bits(DATA_W);
  localparam int unsigned IDX_W  = ADDR_W - LSB;

  if (HAS_CMP) begin : g_cmp
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] alarm;
    logic             met;

    alarm_decode #(.ADDR_W(ADDR_W), .LSB(LSB), .NWORDS(NWORDS)) dec_i (
      .addr_i (bus_addr_i),
      .hit_o  (hit),
      .idx_o  (idx)
    );

    alarm_store #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) store_i (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (bus_wr_i),
      .rd_i    (bus_rd_i),
      .hit_i   (hit),
      .idx_i   (idx),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .value_o (alarm)
    );

    alarm_ge #(.DATA_W(DATA_W), .NWORDS(NWORDS)) ge_i (
      .count_i (timebase_i),
      .alarm_i (alarm),
      .ge_o    (met)
    );

    alarm_pend pend_i (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (bus_wr_i && hit),
      .met_i  (met),
      .pend_o (irq_o)
    );
  end else begin : g_inert
    assign bus_rdata_o = '0;
    assign irq_o       = 1'b0;
  end

endmodule

// File: tb/hart_alarm_tb_top.sv
module hart_alarm_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tb_cnt = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic        irq_a, irq_b;

  int n_chk = 0;
  int n_bad = 0;
  bit nc_seen = 1'b0;

  always #10 clk = ~clk;

  hart_alarm dut_i (
    .clk(clk), .rst(rst), .timebase_i(tb_cnt), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata_a), .irq_o(irq_a)
  );

  hart_alarm #(.HAS_CMP(1'b0)) dut_nc_i (
    .clk(clk), .rst(rst), .timebase_i(tb_cnt), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata_b), .irq_o(irq_b)
  );

  always @(negedge clk) if (!rst && irq_b) nc_seen = 1'b1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] ra, output logic [31:0] rb);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    ra = rdata_a; rb = rdata_b;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 irq after reset", 64'(irq_a), 64'd0);
    chk("R1 rdata after reset", 64'(rdata_a), 64'd0);
    bus_read(3'h0, a, b);
    chk("R1 low word reset", 64'(a), 64'hFFFF_FFFF);
    bus_read(3'h4, a, b);
    chk("R1 high word reset", 64'(a), 64'hFFFF_FFFF);
  endtask

  task automatic t_post();
    bus_write(3'h0, 32'h10);
    bus_write(3'h4, 32'h1);
    tb_cnt = 64'h1_0000_000F;
    step(2);
    chk("R2 one below no post", 64'(irq_a), 64'd0);
    tb_cnt = 64'h1_0000_0010;
    step(1);
    chk("R2 equal posts", 64'(irq_a), 64'd1);
  endtask

  task automatic t_sticky();
    tb_cnt = 64'h0;
    step(3);
    chk("R3 sticky after count drops", 64'(irq_a), 64'd1);
  endtask

  task automatic t_clear();
    tb_cnt = 64'h1_0000_0020;
    step(1);
    bus_write(3'h4, 32'h1);
    chk("R4 write clears despite met", 64'(irq_a), 64'd0);
    step(1);
    chk("R4 reposts next edge", 64'(irq_a), 64'd1);
    bus_write(3'h0, 32'h30);
    chk("R4 low write clears", 64'(irq_a), 64'd0);
    step(2);
    chk("R4 stays clear below new value", 64'(irq_a), 64'd0);
  endtask

  task automatic t_word();
    logic [31:0] a, b;
    tb_cnt = 64'h1_FFFF_FFFF;
    bus_write(3'h0, 32'h100);
    bus_write(3'h4, 32'h2);
    step(1);
    chk("R6 upper word lower no post", 64'(irq_a), 64'd0);
    tb_cnt = 64'h3_0000_0000;
    step(1);
    chk("R6 64-bit compare posts", 64'(irq_a), 64'd1);
    bus_read(3'h0, a, b);
    chk("R6 low word at 0x0", 64'(a), 64'h100);
    bus_read(3'h4, a, b);
    chk("R6 high word at 0x4", 64'(a), 64'h2);
  endtask

  task automatic t_rdwr();
    logic [31:0] a, b;
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 3'h0; bus_wdata = 32'hAAAA_5555;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R5 read during write old value", 64'(rdata_a), 64'h100);
    step(2);
    chk("R5 rdata holds without read", 64'(rdata_a), 64'h100);
    bus_read(3'h0, a, b);
    chk("R5 read after write new value", 64'(a), 64'hAAAA_5555);
  endtask

  task automatic t_bad();
    logic [31:0] a, b;
    step(1);
    chk("R7 pending before bad write", 64'(irq_a), 64'd1);
    bus_write(3'h2, 32'h0);
    chk("R7 bad offset write no clear", 64'(irq_a), 64'd1);
    bus_read(3'h1, a, b);
    chk("R7 bad offset reads zero", 64'(a), 64'd0);
    bus_read(3'h6, a, b);
    chk("R7 offset 6 reads zero", 64'(a), 64'd0);
    bus_read(3'h0, a, b);
    chk("R7 low word untouched", 64'(a), 64'hAAAA_5555);
  endtask

  task automatic t_safe();
    bus_write(3'h4, 32'h5);
    bus_write(3'h0, 32'h0);
    tb_cnt = 64'h3_1234_5678;
    step(1);
    chk("R8 start quiet", 64'(irq_a), 64'd0);
    bus_write(3'h0, 32'hFFFF_FFFF);
    step(1);
    chk("R8 after low all ones", 64'(irq_a), 64'd0);
    bus_write(3'h4, 32'h4);
    step(1);
    chk("R8 after new high", 64'(irq_a), 64'd0);
    bus_write(3'h0, 32'h10);
    step(1);
    chk("R8 after new low", 64'(irq_a), 64'd0);
    tb_cnt = 64'h4_0000_0010;
    step(1);
    chk("R8 new target posts", 64'(irq_a), 64'd1);
  endtask

  task automatic t_nocmp();
    logic [31:0] a, b;
    bus_write(3'h0, 32'h0);
    bus_write(3'h4, 32'h0);
    tb_cnt = 64'hFFFF_0000_0000_0000;
    step(2);
    bus_read(3'h0, a, b);
    chk("R9 no-comparator low reads zero", 64'(b), 64'd0);
    bus_read(3'h4, a, b);
    chk("R9 no-comparator high reads zero", 64'(b), 64'd0);
    chk("R9 no-comparator never interrupts", 64'(nc_seen), 64'd0);
  endtask

  initial begin
    t_reset();
    t_post();
    t_sticky();
    t_clear();
    t_word();
    t_rdwr();
    t_bad();
    t_safe();
    t_nocmp();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule